// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

This block is a bank of general-purpose I/O pins behind a simple register bus. Every pin has an output latch and an output-enable latch. Software never writes either latch directly. It writes a mask to a "set" address or a "clear" address, and only the pins whose mask bit is 1 change. Two agents can therefore own different pins of the same bank without a read-modify-write sequence and without races between them.

The pad side sees the output value and the output-enable vector straight from the latches. It also supplies an input vector, which passes through a two-flop synchronizer before software can read it. The bus accepts at most one write per cycle. Read data is registered and appears on the cycle after the read strobe. It is zero in every other cycle.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, every output latch and every output-enable latch is 0 (all pins tristate), and the read data is 0.
- R2: A write to offset 0x00 sets the output latch of each pin whose data bit is 1 and leaves the other pins unchanged. The change shows on the pad outputs in the cycle after the write.
- R3: A write to offset 0x10 clears the output latch of each pin whose data bit is 1 and leaves the other pins unchanged.
- R4: A write to offset 0x20 sets the output-enable bit of each pin whose data bit is 1 and leaves the other pins unchanged.
- R5: A write to offset 0x30 clears the output-enable bit of each pin whose data bit is 1 and leaves the other pins unchanged.
- R6: A read of offset 0x40 returns the pad input levels, bit n for pin n, after a two-flop synchronizer. A read issued in the cycle the input changes returns the old value, and so does a read issued one cycle later. A read issued two cycles after the change returns the new value.
- R7: Reads of 0x00 and 0x10 return the output latches. Reads of 0x20 and 0x30 return the output-enable latches. Read data appears in the cycle after the read strobe and is 0 in any cycle that follows no read.
- R8: Any other offset in the 8-bit window reads as 0, including unaligned offsets such as 0x04 or 0x01. A write to such an offset, or to the input offset 0x40, changes neither latch.
- R9: Writes apply in bus order, one per cycle. When a set and a clear to the same latch follow each other in back-to-back cycles, the later one decides the final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write mask, one bit per pin |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| pad_out | output | 32 | Output latch value per pin |
| pad_oe | output | 32 | Output enable per pin, 1 drives the pad |
| pad_in | input | 32 | Asynchronous pad input levels |

## Verification
A vector table of sets and clears is run through the bank. The masks overlap bits already set, touch bits already clear and mix disjoint nibbles, which tells a true masked set or clear apart from a plain overwrite or from the wrong latch being hit. Readback at all four latch offsets separates the output and enable paths. Three consecutive reads after an input change pin down the exact synchronizer latency. Writes to unaligned, unmapped and read-only offsets, and back-to-back set/clear pairs in both orders, show that decoding is exact and that bus order decides the result.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  // Byte offsets: software decodes these, so they are fixed.
  localparam int unsigned OFS_OUT_SET = 32'h00;
  localparam int unsigned OFS_OUT_CLR = 32'h10;
  localparam int unsigned OFS_OE_SET  = 32'h20;
  localparam int unsigned OFS_OE_CLR  = 32'h30;
  localparam int unsigned OFS_IN_LVL  = 32'h40;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_OUT  = 2'd1,
    RSEL_OE   = 2'd2,
    RSEL_IN   = 2'd3
  } rsel_e;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          we,
  output logic          wr_set_out,
  output logic          wr_clr_out,
  output logic          wr_set_oe,
  output logic          wr_clr_oe,
  output rsel_e         rsel
);
  logic hit_out_set, hit_out_clr, hit_oe_set, hit_oe_clr, hit_in;

  assign hit_out_set = (addr == AW'(OFS_OUT_SET));
  assign hit_out_clr = (addr == AW'(OFS_OUT_CLR));
  assign hit_oe_set  = (addr == AW'(OFS_OE_SET));
  assign hit_oe_clr  = (addr == AW'(OFS_OE_CLR));
  assign hit_in      = (addr == AW'(OFS_IN_LVL));

  assign wr_set_out = we && hit_out_set;
  assign wr_clr_out = we && hit_out_clr;
  assign wr_set_oe  = we && hit_oe_set;
  assign wr_clr_oe  = we && hit_oe_clr;

  always_comb begin
    if (hit_out_set || hit_out_clr)    rsel = RSEL_OUT;
    else if (hit_oe_set || hit_oe_clr) rsel = RSEL_OE;
    else if (hit_in)                   rsel = RSEL_IN;
    else                               rsel = RSEL_ZERO;
  end
endmodule

// File: rtl/gpio_sc_maskreg.sv
module gpio_sc_maskreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                            input logic [W-1:0] m,
                                            input logic s, input logic c);
    logic [W-1:0] r;
    r = cur;
    if (s) r = r | m;
    if (c) r = r & ~m;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_val(q, mask, set_stb, clr_stb);
  end
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_sc_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int AW      = 8,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] pad_in
);
  // Named internal events, used by the bound checker.
  logic             wr_set_out, wr_clr_out, wr_set_oe, wr_clr_oe;
  rsel_e            rsel;
  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] rd_mux;

  gpio_sc_decode #(.AW(AW)) u_dec (
    .addr       (bus_addr),
    .we         (bus_we),
    .wr_set_out (wr_set_out),
    .wr_clr_out (wr_clr_out),
    .wr_set_oe  (wr_set_oe),
    .wr_clr_oe  (wr_clr_oe),
    .rsel       (rsel)
  );

  gpio_sc_maskreg #(.W(NPINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_set_out),
    .clr_stb (wr_clr_out),
    .mask    (bus_wdata),
    .q       (pad_out)
  );

  gpio_sc_maskreg #(.W(NPINS)) u_oe (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_set_oe),
    .clr_stb (wr_clr_oe),
    .mask    (bus_wdata),
    .q       (pad_oe)
  );

  gpio_sc_sync #(.W(NPINS), .STAGES(SYNC_FF)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  always_comb begin
    unique case (rsel)
      RSEL_OUT: rd_mux = pad_out;
      RSEL_OE:  rd_mux = pad_oe;
      RSEL_IN:  rd_mux = in_sync;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic             bus_we,
  input logic             bus_re,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_in,
  input logic             wr_set_out,
  input logic             wr_clr_out,
  input logic             wr_set_oe,
  input logic             wr_clr_oe
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  a_r2_set_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_out |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

  a_r3_clr_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_out |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

  a_r4_set_oe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set_oe |=> pad_oe == ($past(pad_oe) | $past(bus_wdata)));

  a_r5_clr_oe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_oe |=> pad_oe == ($past(pad_oe) & ~$past(bus_wdata)));

  a_r6_input_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && bus_re && bus_addr == AW'(8'h40)) |=> bus_rdata == $past(pad_in, 3));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);

  a_r7_read_out: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == AW'(8'h00)) |=> bus_rdata == $past(pad_out));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set_out || wr_clr_out) |=> $stable(pad_out));

  a_r8_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set_oe || wr_clr_oe) |=> $stable(pad_oe));

  a_r8_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |-> !(wr_set_out || wr_clr_out || wr_set_oe || wr_clr_oe));

  a_r9_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_set_out, wr_clr_out, wr_set_oe, wr_clr_oe}));
endmodule

bind gpio_setclr_bank gpio_setclr_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_rdata  (bus_rdata),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_in     (pad_in),
  .wr_set_out (wr_set_out),
  .wr_clr_out (wr_clr_out),
  .wr_set_oe  (wr_set_oe),
  .wr_clr_oe  (wr_clr_oe)
);

// File: tb/gpio_setclr_bank_tb.sv
module gpio_setclr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [31:0] pad_in = 32'h1234_5678;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // {addr, mask, expected pad_out, expected pad_oe} after each write
  localparam logic [103:0] VEC [NV] = '{
    {8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'h0000_0000},
    {8'h10, 32'h0000_000F, 32'hA5A5_0F00, 32'h0000_0000},
    {8'h20, 32'hFFFF_0000, 32'hA5A5_0F00, 32'hFFFF_0000},
    {8'h00, 32'h0000_00F0, 32'hA5A5_0FF0, 32'hFFFF_0000},
    {8'h30, 32'h0F0F_0000, 32'hA5A5_0FF0, 32'hF0F0_0000},
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0000, 32'hF0F0_0000},
    {8'h20, 32'h0000_0001, 32'h0000_0000, 32'hF0F0_0001},
    {8'h00, 32'h8000_0001, 32'h8000_0001, 32'hF0F0_0001}
  };

  gpio_setclr_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_in    (pad_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] r;
    string tag;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out", pad_out, 32'h0);
    check("R1 oe", pad_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out after release", pad_out, 32'h0);

    // Table walk: R2 set out, R3 clear out, R4 set oe, R5 clear oe
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][103:96], VEC[i][95:64]);
      case (VEC[i][103:96])
        8'h00:   tag = "R2";
        8'h10:   tag = "R3";
        8'h20:   tag = "R4";
        default: tag = "R5";
      endcase
      check({tag, " out"}, pad_out, VEC[i][63:32]);
      check({tag, " oe"}, pad_oe, VEC[i][31:0]);
    end

    // R7: latch readback, idle zero
    rd(8'h00, r); check("R7 rd 0x00", r, 32'h8000_0001);
    rd(8'h10, r); check("R7 rd 0x10", r, 32'h8000_0001);
    rd(8'h20, r); check("R7 rd 0x20", r, 32'hF0F0_0001);
    rd(8'h30, r); check("R7 rd 0x30", r, 32'hF0F0_0001);
    @(negedge clk);
    check("R7 idle zero", bus_rdata, 32'h0);

    // R6: input path latency
    rd(8'h40, r); check("R6 steady", r, 32'h1234_5678);
    @(negedge clk);
    pad_in = 32'hCAFE_0042;
    bus_re = 1'b1; bus_addr = 8'h40;
    @(negedge clk); check("R6 same cycle old", bus_rdata, 32'h1234_5678);
    @(negedge clk); check("R6 one cycle old", bus_rdata, 32'h1234_5678);
    @(negedge clk); check("R6 two cycles new", bus_rdata, 32'hCAFE_0042);
    bus_re = 1'b0;

    // R8: unmapped reads and ignored writes
    rd(8'h04, r); check("R8 rd 0x04", r, 32'h0);
    rd(8'h01, r); check("R8 rd 0x01", r, 32'h0);
    rd(8'h44, r); check("R8 rd 0x44", r, 32'h0);
    rd(8'hFC, r); check("R8 rd 0xFC", r, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'hFF, 32'hFFFF_FFFF);
    check("R8 out untouched", pad_out, 32'h8000_0001);
    check("R8 oe untouched", pad_oe, 32'hF0F0_0001);

    // R9: back-to-back set/clear, later write decides
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0000_0F00;
    @(negedge clk);
    bus_addr = 8'h10;
    @(negedge clk);
    bus_we = 1'b0;
    check("R9 set then clear", pad_out, 32'h8000_0001);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0000_0F00;
    @(negedge clk);
    bus_addr = 8'h20;
    @(negedge clk);
    bus_we = 1'b0;
    check("R9 clear then set", pad_oe, 32'hF0F0_0F01);

    // R1: reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset out", pad_out, 32'h0);
    check("R1 re-reset oe", pad_oe, 32'h0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule